// File: doc/BRIEF.md
# Configuration Cycle Address Translator

This block sits on the host side of a PCI bridge and implements configuration mechanism #1. Software writes a target address (bus, device, function, register and an enable flag) into an address register at I/O port 0CF8h. It then reads or writes the data port at 0CFCh. The block turns each enabled data-port access into one request to the bus engine downstream. That request is a configuration read, a configuration write or a special cycle, and it carries a translated address, the data and the byte enables. The bus signalling itself is handled elsewhere.

The translation depends on the target bus. A bus number equal to the bridge's own (parameter, 00h by default) gives a Type 0 address. Any other bus gives a Type 1 address. A special address pattern turns the next data-port write into a special cycle whose message is the written data. Two dedicated inputs, halt and shutdown, issue fixed special-cycle messages without any software setup. Only one downstream request is outstanding at a time. The block stays busy until the bus engine signals completion.

The host side uses a held request. The host raises `io_req` and keeps it high until it sees a one-cycle `io_ack`.

Top module: `cfgx_top`

## Requirements
- R1: After reset the address register reads 0. A write to 0CF8h with all four byte enables set stores the data. A write with any byte enable clear leaves the register unchanged. A read of 0CF8h returns the stored value with bits 30:24 as zero. `io_ack` rises one cycle after the request is accepted.
- R2: When address bit 31 is 0, a 0CFCh access is acknowledged with `io_pass`=1 and produces no downstream request.
- R3: With bit 31 set and bus (bits 23:16) equal to BRIDGE_BUS, a 0CFCh read or write issues kind 0 (read) or 1 (write). The issued address is {8'h00, bus, device[15:11], function[10:8], register[7:2], 2'b00}.
- R4: When the bus differs from BRIDGE_BUS, the issued address has the same layout but bits 1:0 are 2'b01.
- R5: With bus = BRIDGE_BUS, device = 11111b, function = 111b and register = 0, a 0CFCh write issues kind 2 (special) with address 0 and the written data as the message.
- R6: A 0CFCh read with that special pattern is acknowledged one cycle after acceptance with data FFFFFFFFh and produces no downstream request.
- R7: The special pattern on a bus other than BRIDGE_BUS is issued as an ordinary Type 1 configuration write.
- R8: `busy` and `cyc_valid` stay high, with address and data stable, from the issue cycle until the cycle after `cyc_done`. While busy, 0CFCh accesses are held without acknowledge. 0CF8h accesses are still served.
- R9: A host-issued request is acknowledged in the cycle after `cyc_done`. For a read, `io_rdata` equals `cyc_rdata`.
- R10: A pulse on `halt_req` issues a special cycle with message 00000001h. A pulse on `shut_req` issues one with message 00000000h. Neither produces `io_ack`. A request that arrives while busy is kept and issued later.
- R11: A built-in request wins over a host 0CFCh access arriving in the same cycle. Shutdown wins over halt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_req | input | 1 | Host I/O request, held until io_ack |
| io_we | input | 1 | 1 = write, 0 = read |
| io_addr | input | IO_AW | Host I/O port address |
| io_be | input | 4 | Byte enables |
| io_wdata | input | 32 | Write data |
| io_ack | output | 1 | One-cycle acknowledge |
| io_pass | output | 1 | Data-port access not translated (enable clear) |
| io_rdata | output | 32 | Read data, valid with io_ack |
| halt_req | input | 1 | Built-in halt message request (pulse) |
| shut_req | input | 1 | Built-in shutdown message request (pulse) |
| busy | output | 1 | Downstream request outstanding |
| cyc_valid | output | 1 | Downstream request valid |
| cyc_kind | output | 2 | 0 read, 1 write, 2 special |
| cyc_addr | output | 32 | Translated address |
| cyc_data | output | 32 | Write data or special message |
| cyc_be | output | 4 | Byte enables of the request |
| cyc_done | input | 1 | Downstream request completed |
| cyc_rdata | input | 32 | Read data returned with cyc_done |

## Verification
Two functions can fall in the same cycle: a built-in halt or shutdown request and a host access to the data port. A further collision is halt together with shutdown. The bench provokes both by driving the request pulse and the host request on the same clock edge. It judges the result by the order in which the downstream requests reach the scoreboard, built-in first and shutdown before halt. It also confirms that the held host access is completed afterwards with its own acknowledge.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;
  localparam int unsigned DW  = 32;
  localparam int unsigned BEW = DW / 8;

  typedef enum logic [1:0] {
    CYC_RD  = 2'd0,
    CYC_WR  = 2'd1,
    CYC_SPC = 2'd2
  } cyc_kind_e;

  localparam logic [4:0] SPC_DEV = 5'h1F;
  localparam logic [2:0] SPC_FN  = 3'h7;
  localparam logic [5:0] SPC_REG = 6'h00;
endpackage

// File: rtl/cfgx_addr_reg.sv
module cfgx_addr_reg
  import cfgx_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic [BEW-1:0] be,
  input  logic [DW-1:0]  wdata,
  output logic [DW-1:0]  ca_q
);
  // reserved bits 30:24 are dropped at write time so every read shows zero
  always_ff @(posedge clk) begin
    if (rst) begin
      ca_q <= '0;
    end else if (wr_en && (&be)) begin
      ca_q <= {wdata[31], 7'b0, wdata[23:0]};
    end
  end

  p_partial_keep_r1: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !(&be)) |=> $stable(ca_q));
  p_full_load_r1: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (&be)) |=> (ca_q[23:0] == $past(wdata[23:0]) && ca_q[30:24] == 7'b0));
endmodule

// File: rtl/cfgx_decode.sv
module cfgx_decode
  import cfgx_pkg::*;
#(
  parameter logic [7:0] BRIDGE_BUS = 8'h00
) (
  input  logic [21:0]   fields,   // address register bits 23:2
  output logic          is_spc,
  output logic [DW-1:0] xaddr
);
  logic [7:0] bus;
  logic [4:0] dev;
  logic [2:0] fn;
  logic [5:0] rg;
  logic       local_bus;

  always_comb begin
    bus       = fields[21:14];
    dev       = fields[13:9];
    fn        = fields[8:6];
    rg        = fields[5:0];
    local_bus = (bus == BRIDGE_BUS);
    is_spc    = local_bus && (dev == SPC_DEV) && (fn == SPC_FN) && (rg == SPC_REG);
    xaddr     = {8'h00, bus, dev, fn, rg, (local_bus ? 2'b00 : 2'b01)};
  end
endmodule

// File: rtl/cfgx_issue.sv
module cfgx_issue
  import cfgx_pkg::*;
#(
  parameter logic [7:0]    BRIDGE_BUS = 8'h00,
  parameter logic [DW-1:0] MSG_HALT   = 32'h0000_0001,
  parameter logic [DW-1:0] MSG_SHUT   = 32'h0000_0000
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           io_req,
  input  logic           io_we,
  input  logic [BEW-1:0] io_be,
  input  logic [DW-1:0]  io_wdata,
  input  logic           hit_ca,
  input  logic           hit_cd,
  input  logic [DW-1:0]  ca_q,
  input  logic           is_spc,
  input  logic [DW-1:0]  xaddr,
  input  logic           halt_req,
  input  logic           shut_req,
  input  logic           cyc_done,
  input  logic [DW-1:0]  cyc_rdata,
  output logic           ca_wr,
  output logic           io_ack,
  output logic           io_pass,
  output logic [DW-1:0]  io_rdata,
  output logic           busy,
  output cyc_kind_e      cyc_kind,
  output logic [DW-1:0]  cyc_addr,
  output logic [DW-1:0]  cyc_data,
  output logic [BEW-1:0] cyc_be
);
  logic pend_halt, pend_shut, own_q;
  logic bi_halt, bi_shut, bi_any, bi_go;
  logic acc, acc_ca, acc_cd, ca_en, cd_issue;

  always_comb begin
    ca_en    = ca_q[31];
    bi_shut  = pend_shut | shut_req;
    bi_halt  = pend_halt | halt_req;
    bi_any   = bi_shut | bi_halt;
    bi_go    = !busy && bi_any;
    acc      = io_req && !io_ack && (hit_ca || (hit_cd && !busy && !bi_any));
    acc_ca   = acc && hit_ca;
    acc_cd   = acc && hit_cd;
    ca_wr    = acc_ca && io_we;
    cd_issue = acc_cd && ca_en && !(is_spc && !io_we);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_halt <= 1'b0;
      pend_shut <= 1'b0;
      own_q     <= 1'b0;
      busy      <= 1'b0;
      io_ack    <= 1'b0;
      io_pass   <= 1'b0;
      io_rdata  <= '0;
      cyc_kind  <= CYC_RD;
      cyc_addr  <= '0;
      cyc_data  <= '0;
      cyc_be    <= '0;
    end else begin
      io_ack    <= 1'b0;
      io_pass   <= 1'b0;
      pend_shut <= bi_shut && !bi_go;
      pend_halt <= bi_halt && !(bi_go && !bi_shut);
      if (bi_go) begin
        busy     <= 1'b1;
        own_q    <= 1'b0;
        cyc_kind <= CYC_SPC;
        cyc_addr <= '0;
        cyc_data <= bi_shut ? MSG_SHUT : MSG_HALT;
        cyc_be   <= '1;
      end else if (cd_issue) begin
        busy     <= 1'b1;
        own_q    <= 1'b1;
        cyc_kind <= is_spc ? CYC_SPC : (io_we ? CYC_WR : CYC_RD);
        cyc_addr <= is_spc ? '0 : xaddr;
        cyc_data <= io_we ? io_wdata : '0;
        cyc_be   <= io_be;
      end else if (busy && cyc_done) begin
        busy <= 1'b0;
        if (own_q) begin
          io_ack   <= 1'b1;
          io_rdata <= cyc_rdata;
        end
      end
      if (acc_ca) begin
        io_ack   <= 1'b1;
        io_rdata <= ca_q;
      end
      if (acc_cd && !ca_en) begin
        io_ack   <= 1'b1;
        io_pass  <= 1'b1;
        io_rdata <= '0;
      end
      if (acc_cd && ca_en && is_spc && !io_we) begin
        io_ack   <= 1'b1;
        io_rdata <= '1;
      end
    end
  end

  p_done_release_r8: assert property (@(posedge clk) disable iff (rst)
    (busy && cyc_done) |=> !busy);
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (busy && !cyc_done) |=> (busy && $stable(cyc_addr) && $stable(cyc_data)));
  p_ack_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    io_ack |=> !io_ack);
  p_type_bits_r4: assert property (@(posedge clk) disable iff (rst)
    (busy && cyc_kind != CYC_SPC) |->
      (cyc_addr[1:0] == ((cyc_addr[23:16] == BRIDGE_BUS) ? 2'b00 : 2'b01)));
  p_spc_addr_r5: assert property (@(posedge clk) disable iff (rst)
    (busy && cyc_kind == CYC_SPC) |-> (cyc_addr == '0));
  p_builtin_first_r11: assert property (@(posedge clk) disable iff (rst)
    (!busy && (halt_req || shut_req)) |=> (busy && cyc_kind == CYC_SPC && !own_q));
endmodule

// File: rtl/cfgx_top.sv
module cfgx_top
  import cfgx_pkg::*;
#(
  parameter int unsigned       IO_AW      = 16,
  parameter logic [IO_AW-1:0]  CA_PORT    = 16'h0CF8,
  parameter logic [IO_AW-1:0]  CD_PORT    = 16'h0CFC,
  parameter logic [7:0]        BRIDGE_BUS = 8'h00,
  parameter logic [31:0]       MSG_HALT   = 32'h0000_0001,
  parameter logic [31:0]       MSG_SHUT   = 32'h0000_0000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             io_req,
  input  logic             io_we,
  input  logic [IO_AW-1:0] io_addr,
  input  logic [3:0]       io_be,
  input  logic [31:0]      io_wdata,
  output logic             io_ack,
  output logic             io_pass,
  output logic [31:0]      io_rdata,
  input  logic             halt_req,
  input  logic             shut_req,
  output logic             busy,
  output logic             cyc_valid,
  output logic [1:0]       cyc_kind,
  output logic [31:0]      cyc_addr,
  output logic [31:0]      cyc_data,
  output logic [3:0]       cyc_be,
  input  logic             cyc_done,
  input  logic [31:0]      cyc_rdata
);
  logic          hit_ca, hit_cd, ca_wr, is_spc;
  logic [DW-1:0] ca_q, xaddr;
  cyc_kind_e     kind;

  assign hit_ca    = (io_addr == CA_PORT);
  assign hit_cd    = (io_addr == CD_PORT);
  assign cyc_valid = busy;
  assign cyc_kind  = kind;

  cfgx_addr_reg u_areg (
    .clk(clk), .rst(rst), .wr_en(ca_wr), .be(io_be), .wdata(io_wdata), .ca_q(ca_q)
  );

  cfgx_decode #(.BRIDGE_BUS(BRIDGE_BUS)) u_dec (
    .fields(ca_q[23:2]), .is_spc(is_spc), .xaddr(xaddr)
  );

  cfgx_issue #(.BRIDGE_BUS(BRIDGE_BUS), .MSG_HALT(MSG_HALT), .MSG_SHUT(MSG_SHUT)) u_iss (
    .clk(clk), .rst(rst), .io_req(io_req), .io_we(io_we), .io_be(io_be),
    .io_wdata(io_wdata), .hit_ca(hit_ca), .hit_cd(hit_cd), .ca_q(ca_q),
    .is_spc(is_spc), .xaddr(xaddr), .halt_req(halt_req), .shut_req(shut_req),
    .cyc_done(cyc_done), .cyc_rdata(cyc_rdata), .ca_wr(ca_wr), .io_ack(io_ack),
    .io_pass(io_pass), .io_rdata(io_rdata), .busy(busy), .cyc_kind(kind),
    .cyc_addr(cyc_addr), .cyc_data(cyc_data), .cyc_be(cyc_be)
  );
endmodule

// File: tb/cfgx_top_tb.sv
`timescale 1ns/1ps
module cfgx_top_tb;
  localparam logic [15:0] CA = 16'h0CF8;
  localparam logic [15:0] CD = 16'h0CFC;
  localparam logic [7:0]  BB = 8'h00;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic io_req = 0, io_we = 0;
  logic [15:0] io_addr = '0;
  logic [3:0]  io_be = '0;
  logic [31:0] io_wdata = '0;
  logic io_ack, io_pass, busy, cyc_valid;
  logic [31:0] io_rdata, cyc_addr, cyc_data;
  logic [1:0] cyc_kind;
  logic [3:0] cyc_be;
  logic halt_req = 0, shut_req = 0, cyc_done = 0;
  logic [31:0] cyc_rdata = '0;

  always #2.5 clk = ~clk;

  cfgx_top u_dut (
    .clk(clk), .rst(rst), .io_req(io_req), .io_we(io_we), .io_addr(io_addr),
    .io_be(io_be), .io_wdata(io_wdata), .io_ack(io_ack), .io_pass(io_pass),
    .io_rdata(io_rdata), .halt_req(halt_req), .shut_req(shut_req), .busy(busy),
    .cyc_valid(cyc_valid), .cyc_kind(cyc_kind), .cyc_addr(cyc_addr),
    .cyc_data(cyc_data), .cyc_be(cyc_be), .cyc_done(cyc_done), .cyc_rdata(cyc_rdata)
  );

  int checks = 0, failures = 0;
  int rsp_lat = 2;
  logic [31:0] rsp_data = 32'hA5A5_0001;
  string cur_req = "R1";
  logic [65:0] expq[$];
  logic done_flag = 0;

  task automatic chk(input logic ok, input string rq, input logic [65:0] act, input logic [65:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", rq, act, exp);
    end
  endtask

  function automatic logic [31:0] xl(input logic [31:0] ca);
    return {8'h00, ca[23:2], (ca[23:16] == BB) ? 2'b00 : 2'b01};
  endfunction

  // downstream responder
  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk);
      if (cyc_done) cyc_done = 1'b0;
      else if (cyc_valid) begin
        if (cnt >= rsp_lat) begin cyc_done = 1'b1; cyc_rdata = rsp_data; cnt = 0; end
        else cnt++;
      end
    end
  end

  // scoreboard monitor
  initial begin
    logic prev = 0;
    forever begin
      @(negedge clk);
      if (cyc_valid && !prev) begin
        if (expq.size() == 0) chk(1'b0, cur_req, {cyc_kind, cyc_addr, cyc_data}, 66'h0);
        else begin
          logic [65:0] e;
          e = expq.pop_front();
          chk({cyc_kind, cyc_addr, cyc_data} == e, cur_req, {cyc_kind, cyc_addr, cyc_data}, e);
        end
      end
      prev = cyc_valid;
    end
  end

  task automatic host(input logic we, input logic [15:0] a, input logic [3:0] be,
                      input logic [31:0] wd, output logic [31:0] rd, output logic ps, output int lat);
    @(negedge clk);
    io_req = 1; io_we = we; io_addr = a; io_be = be; io_wdata = wd; lat = 0;
    while (1) begin
      @(posedge clk); #1; lat++;
      if (io_ack) break;
      if (lat > 500) begin chk(1'b0, cur_req, 66'(lat), 66'd0); break; end
    end
    rd = io_rdata; ps = io_pass;
    @(negedge clk); io_req = 0;
  endtask

  task automatic pulse_halt(); @(negedge clk); halt_req = 1; @(negedge clk); halt_req = 0; endtask
  task automatic pulse_shut(); @(negedge clk); shut_req = 1; @(negedge clk); shut_req = 0; endtask
  task automatic settle(input int n); repeat (n) @(negedge clk); endtask

  initial begin
    repeat (40000) @(posedge clk);
    if (!done_flag) begin
      failures++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd; logic ps; int lat; int acks;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(!io_ack && !busy && !cyc_valid, "R1", {io_ack, busy}, 0);
    host(0, CA, 4'hF, 0, rd, ps, lat);
    chk(rd == 0, "R1", rd, 0);
    chk(lat == 1, "R1", lat, 1);
    // R1 full write, reserved bits read zero, partial write ignored
    host(1, CA, 4'hF, 32'hFF12_3456, rd, ps, lat);
    host(0, CA, 4'hF, 0, rd, ps, lat);
    chk(rd == 32'h8012_3456, "R1", rd, 32'h8012_3456);
    host(1, CA, 4'h3, 32'h0, rd, ps, lat);
    host(0, CA, 4'hF, 0, rd, ps, lat);
    chk(rd == 32'h8012_3456, "R1", rd, 32'h8012_3456);

    // R2 disabled passthrough
    cur_req = "R2";
    host(1, CA, 4'hF, 32'h0000_0800, rd, ps, lat);
    host(1, CD, 4'hF, 32'h1111_2222, rd, ps, lat);
    chk(ps == 1, "R2", ps, 1);
    settle(10);
    chk(!busy && expq.size() == 0, "R2", busy, 0);

    // R3 Type 0 read, R9 read data return
    cur_req = "R3";
    rsp_data = 32'hCAFE_0042;
    host(1, CA, 4'hF, 32'h8000_5A3C, rd, ps, lat);
    expq.push_back({2'd0, xl(32'h8000_5A3C), 32'h0});
    host(0, CD, 4'hF, 0, rd, ps, lat);
    chk(rd == 32'hCAFE_0042 && ps == 0, "R9", rd, 32'hCAFE_0042);
    chk(xl(32'h8000_5A3C) == 32'h0000_5A3C, "R3", xl(32'h8000_5A3C), 32'h5A3C);

    // R4 Type 1 write
    cur_req = "R4";
    host(1, CA, 4'hF, 32'h8003_1004, rd, ps, lat);
    expq.push_back({2'd1, 32'h0003_1005, 32'hDEAD_BEEF});
    host(1, CD, 4'hF, 32'hDEAD_BEEF, rd, ps, lat);
    chk(ps == 0, "R4", ps, 0);

    // R5 special write
    cur_req = "R5";
    host(1, CA, 4'hF, 32'h8000_FF00, rd, ps, lat);
    expq.push_back({2'd2, 32'h0, 32'h0000_1234});
    host(1, CD, 4'hF, 32'h0000_1234, rd, ps, lat);
    settle(3);
    chk(expq.size() == 0, "R5", expq.size(), 0);

    // R6 special read
    cur_req = "R6";
    host(0, CD, 4'hF, 0, rd, ps, lat);
    chk(rd == 32'hFFFF_FFFF && lat == 1, "R6", rd, 32'hFFFF_FFFF);
    settle(10);
    chk(!busy, "R6", busy, 0);

    // R7 pattern on foreign bus
    cur_req = "R7";
    host(1, CA, 4'hF, 32'h8005_FF00, rd, ps, lat);
    expq.push_back({2'd1, 32'h0005_FF01, 32'h0000_0077});
    host(1, CD, 4'hF, 32'h0000_0077, rd, ps, lat);
    settle(3);
    chk(expq.size() == 0, "R7", expq.size(), 0);

    // R10 built-in messages, no io_ack
    cur_req = "R10";
    acks = 0;
    expq.push_back({2'd2, 32'h0, 32'h0000_0001});
    pulse_halt();
    repeat (12) begin @(negedge clk); if (io_ack) acks++; end
    expq.push_back({2'd2, 32'h0, 32'h0000_0000});
    pulse_shut();
    repeat (12) begin @(negedge clk); if (io_ack) acks++; end
    chk(acks == 0 && expq.size() == 0, "R10", acks, 0);

    // R8 blocking while busy, CF8 still served
    cur_req = "R8";
    rsp_lat = 8;
    host(1, CA, 4'hF, 32'h8000_0810, rd, ps, lat);
    expq.push_back({2'd2, 32'h0, 32'h0000_0001});
    pulse_halt();
    host(0, CA, 4'hF, 0, rd, ps, lat);
    chk(lat == 1 && busy && rd == 32'h8000_0810, "R8", lat, 1);
    expq.push_back({2'd1, xl(32'h8000_0810), 32'h0000_0099});
    host(1, CD, 4'hF, 32'h0000_0099, rd, ps, lat);
    chk(lat > 8, "R8", lat, 9);
    settle(2);
    chk(!busy && expq.size() == 0, "R8", busy, 0);

    // R11 same-cycle collisions
    cur_req = "R11";
    rsp_lat = 3;
    expq.push_back({2'd2, 32'h0, 32'h0000_0001});
    expq.push_back({2'd1, xl(32'h8000_0810), 32'h0000_00AB});
    fork
      pulse_halt();
      host(1, CD, 4'hF, 32'h0000_00AB, rd, ps, lat);
    join
    chk(lat > 3 && expq.size() == 0, "R11", expq.size(), 0);
    settle(4);
    expq.push_back({2'd2, 32'h0, 32'h0000_0000});
    expq.push_back({2'd2, 32'h0, 32'h0000_0001});
    fork
      pulse_shut();
      pulse_halt();
    join
    settle(20);
    chk(expq.size() == 0 && !busy, "R11", expq.size(), 0);

    done_flag = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule